// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block produces the column addresses for one SDRAM read or write burst, one address per accepted beat. A single-cycle start pulse captures a start column, a burst-length code and an ordering select. From the next cycle on, the block presents addresses on a valid/ready output stream and marks the final beat with a last flag. Fixed bursts of 1, 2, 4 or 8 beats wrap inside the aligned block that holds the start column. A full-page burst walks every column of the row and keeps going until it is told to stop.

The address stream follows valid/ready rules. A beat is consumed on a clock edge where valid and ready are both high. While ready is low, the presented address and valid are held and the beat counter does not move. The consumer may apply back-pressure for any number of cycles. The stop input is a plain control pin. It marks the beat being presented as the final one, and that beat stays marked until it is consumed. The last flag is the only output that may rise on a stalled beat.

The block can sit inside a memory controller's column path or serve alone as a protocol model. It handles no bank, row, data, latency or command encoding.

Top module: `sdram_col_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, col_valid_o and col_last_o are low.
- R2: After a start pulse, the first beat is presented in the next cycle, and its address equals the captured start column.
- R3: The burst-length code selects the burst length. Codes 0, 1, 2 and 3 give lengths of 1, 2, 4 and 8 beats. Code 7 selects full page. The reserved codes 4, 5 and 6 behave as length 1.
- R4: With ordering select 0 (sequential) and a fixed length L, beat i carries (start & ~(L-1)) | ((start + i) mod L). The bits above log2(L) never change.
- R5: With ordering select 1 (interleaved) and a fixed length L, beat i carries (start & ~(L-1)) | ((start XOR i) & (L-1)).
- R6: In full-page mode, beat i carries (start + i) mod 1024, so column 1023 is followed by column 0. The ordering select is ignored, and col_last_o stays low unless a stop is requested.
- R7: col_last_o is high on beat L-1 of a fixed burst. After that beat is consumed, col_valid_o is low in the next cycle unless a new start arrives.
- R8: While col_valid_o is high and col_ready_i is low, col_addr_o and col_valid_o are held, and no beat is skipped.
- R9: When stop_i is high during a burst of any length, the beat being presented is flagged last. That beat stays flagged until it is consumed, and the burst ends when it is consumed.
- R10: A stop request while no burst is active has no effect. The output stays invalid, and the next burst runs to its full length.
- R11: A start pulse during a burst abandons that burst, and the new burst's first beat is presented in the next cycle. A start pulse takes priority over a stop request in the same cycle.
- R12: While col_ready_i is held high, a beat that is not last is followed by another valid beat in the next cycle, giving one column address per clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse that captures the burst setup |
| start_col_i | input | 10 | Start column |
| bl_code_i | input | 3 | Burst-length code (0..3 = 1/2/4/8, 7 = full page, 4..6 = 1) |
| ilv_i | input | 1 | Ordering select: 0 sequential, 1 interleaved |
| stop_i | input | 1 | Burst-stop request |
| col_valid_o | output | 1 | Column address valid |
| col_ready_i | input | 1 | Consumer ready for the address |
| col_addr_o | output | 10 | Column address of the current beat |
| col_last_o | output | 1 | Current beat is the final one |

## Verification
Some rules are checked by assertions on every cycle:
- the address and valid are held during a stall;
- a start is followed by a valid beat that carries the start column;
- the stream goes idle after a consumed last beat and keeps flowing after a consumed beat that is not last;
- a stop always raises last;
- a full-page burst shows no last without a stop.

The exact wrap orders need the bench's scenarios. The bench sweeps every length code against both orderings and many start columns under a repeating stall pattern, and compares each beat with arithmetic expectations. Only directed scenarios show the other cases: the full-page wrap past column 1023, a stop that stays pending on a stalled beat, a restart in the middle of a burst, and a stop that is ignored while idle.

// File: rtl/sdram_col_pkg.sv
package sdram_col_pkg;
  localparam int          BL_CODE_W      = 3;
  localparam int          MAX_FIXED_LOG2 = 3;
  localparam logic [2:0]  BL_CODE_PAGE   = 3'd7;
endpackage

// File: rtl/sdram_col_len_dec.sv
module sdram_col_len_dec
  import sdram_col_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic [BL_CODE_W-1:0] code_i,
  output logic [COL_W-1:0]     mask_o,
  output logic                 full_o
);
  always_comb begin
    mask_o = '0;
    full_o = 1'b0;
    if (code_i == BL_CODE_PAGE) begin
      mask_o = '1;
      full_o = 1'b1;
    end else if (code_i <= BL_CODE_W'(MAX_FIXED_LOG2)) begin
      for (int i = 0; i < MAX_FIXED_LOG2; i++) begin
        if (i < int'(code_i)) mask_o[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sdram_col_addr_calc.sv
module sdram_col_addr_calc #(
  parameter int COL_W = 10
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] addr_o
);
  logic [COL_W-1:0] walk;

  always_comb begin
    walk   = ilv_i ? (base_i ^ beat_i) : (base_i + beat_i);
    addr_o = (base_i & ~mask_i) | (walk & mask_i);
  end
endmodule

// File: rtl/sdram_col_seq.sv
module sdram_col_seq
  import sdram_col_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [COL_W-1:0]     start_col_i,
  input  logic [BL_CODE_W-1:0] bl_code_i,
  input  logic                 ilv_i,
  input  logic                 stop_i,
  output logic                 col_valid_o,
  input  logic                 col_ready_i,
  output logic [COL_W-1:0]     col_addr_o,
  output logic                 col_last_o
);
  logic             busy_q;
  logic [COL_W-1:0] cnt_q;
  logic [COL_W-1:0] base_q;
  logic [COL_W-1:0] mask_q;
  logic             full_q;
  logic             ilv_q;
  logic             stop_pend_q;

  logic [COL_W-1:0] dec_mask;
  logic             dec_full;
  logic             fire;
  logic             fixed_end;

  sdram_col_len_dec #(.COL_W(COL_W)) u_dec (
    .code_i (bl_code_i),
    .mask_o (dec_mask),
    .full_o (dec_full)
  );

  sdram_col_addr_calc #(.COL_W(COL_W)) u_calc (
    .base_i (base_q),
    .beat_i (cnt_q),
    .mask_i (mask_q),
    .ilv_i  (ilv_q),
    .addr_o (col_addr_o)
  );

  assign col_valid_o = busy_q;
  assign fire        = busy_q & col_ready_i;
  assign fixed_end   = ~full_q & (cnt_q == mask_q);
  assign col_last_o  = busy_q & (fixed_end | stop_pend_q | stop_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      cnt_q       <= '0;
      base_q      <= '0;
      mask_q      <= '0;
      full_q      <= 1'b0;
      ilv_q       <= 1'b0;
      stop_pend_q <= 1'b0;
    end else if (start_i) begin
      busy_q      <= 1'b1;
      cnt_q       <= '0;
      base_q      <= start_col_i;
      mask_q      <= dec_mask;
      full_q      <= dec_full;
      ilv_q       <= ilv_i & ~dec_full;
      stop_pend_q <= 1'b0;
    end else begin
      if (busy_q && stop_i) stop_pend_q <= 1'b1;
      if (fire) begin
        if (col_last_o) begin
          busy_q      <= 1'b0;
          stop_pend_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R8
  hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid_o && !col_ready_i && !start_i |=> col_valid_o && $stable(col_addr_o));

  // R2
  start_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> col_valid_o && (col_addr_o == $past(start_col_i)));

  // R7
  end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid_o && col_ready_i && col_last_o && !start_i |=> !col_valid_o);

  // R12
  stream_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid_o && col_ready_i && !col_last_o |=> col_valid_o);

  // R9
  stop_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid_o && stop_i |-> col_last_o);

  // R6
  page_nolast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid_o && full_q && !stop_i && !stop_pend_q |-> !col_last_o);
endmodule

// File: tb/tb_sdram_col_seq.sv
module tb_sdram_col_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [9:0] start_col_i = '0;
  logic [2:0] bl_code_i = '0;
  logic       ilv_i = 1'b0;
  logic       stop_i = 1'b0;
  logic       col_ready_i = 1'b0;
  logic       col_valid_o;
  logic [9:0] col_addr_o;
  logic       col_last_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sdram_col_seq dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
    .bl_code_i(bl_code_i), .ilv_i(ilv_i), .stop_i(stop_i),
    .col_valid_o(col_valid_o), .col_ready_i(col_ready_i),
    .col_addr_o(col_addr_o), .col_last_o(col_last_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_addr(input int code, input int ilv, input int s, input int i);
    int len;
    if (code == 7) return (s + i) % 1024;
    len = (code <= 3) ? (1 << code) : 1;
    if (ilv != 0) return (s & ~(len - 1)) | ((s ^ i) & (len - 1));
    return (s & ~(len - 1)) | ((s + i) & (len - 1));
  endfunction

  task automatic kick(input int code, input int ilv, input int s);
    @(negedge clk);
    start_i = 1'b1; start_col_i = 10'(s); bl_code_i = 3'(code); ilv_i = ilv[0];
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // Sweep burst: R3, R4, R5, R7, R8, R2
  task automatic run_burst(input int code, input int ilv, input int s);
    int len;
    int i;
    len = (code <= 3) ? (1 << code) : 1;
    kick(code, ilv, s);
    i = 0;
    while (i < len) begin
      cyc++;
      col_ready_i = ((cyc % 5) != 3);
      #1;
      chk(col_valid_o === 1'b1, "R8 valid held", int'(col_valid_o), 1);
      chk(int'(col_addr_o) == exp_addr(code, ilv, s, i),
          (ilv != 0) ? "R5 interleaved addr" : "R4 sequential addr",
          int'(col_addr_o), exp_addr(code, ilv, s, i));
      if (col_ready_i) begin
        chk(col_last_o == (i == len - 1), "R3 R7 last flag", int'(col_last_o), int'(i == len - 1));
        i++;
      end
      @(negedge clk);
    end
    col_ready_i = 1'b1;
    #1;
    chk(col_valid_o == 1'b0, "R7 idle after last", int'(col_valid_o), 0);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog act=1 exp=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    #1;
    chk(col_valid_o == 1'b0, "R1 valid in reset", int'(col_valid_o), 0);
    chk(col_last_o == 1'b0, "R1 last in reset", int'(col_last_o), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    chk(col_valid_o == 1'b0, "R1 valid after reset", int'(col_valid_o), 0);

    // R3 R4 R5 sweep
    for (int c = 0; c < 7; c++)
      for (int m = 0; m < 2; m++)
        for (int s = 0; s < 1024; s += 13)
          run_burst(c, m, s);

    // R6 full page wrap, interleave ignored, then R9 stop
    kick(7, 1, 1020);
    col_ready_i = 1'b1;
    for (int i = 0; i < 10; i++) begin
      #1;
      chk(int'(col_addr_o) == (1020 + i) % 1024, "R6 page addr", int'(col_addr_o), (1020 + i) % 1024);
      chk(col_last_o == 1'b0, "R6 page no last", int'(col_last_o), 0);
      @(negedge clk);
    end
    stop_i = 1'b1; #1;
    chk(col_last_o == 1'b1, "R9 stop page last", int'(col_last_o), 1);
    chk(int'(col_addr_o) == 6, "R9 stop page addr", int'(col_addr_o), 6);
    @(negedge clk); stop_i = 1'b0; #1;
    chk(col_valid_o == 1'b0, "R9 page ended", int'(col_valid_o), 0);

    // R9 stop on stalled fixed burst stays pending
    kick(3, 0, 40);
    col_ready_i = 1'b1;
    @(negedge clk); @(negedge clk);
    col_ready_i = 1'b0; stop_i = 1'b1; #1;
    chk(col_last_o == 1'b1, "R9 stop stalled last", int'(col_last_o), 1);
    @(negedge clk); stop_i = 1'b0; #1;
    chk(col_valid_o == 1'b1 && col_last_o == 1'b1, "R9 stop pending", int'(col_last_o), 1);
    chk(int'(col_addr_o) == 42, "R9 stop pending addr", int'(col_addr_o), 42);
    col_ready_i = 1'b1;
    @(negedge clk); #1;
    chk(col_valid_o == 1'b0, "R9 fixed ended early", int'(col_valid_o), 0);

    // R11 restart mid-burst, start beats stop
    kick(3, 0, 5);
    col_ready_i = 1'b1;
    @(negedge clk); @(negedge clk);
    start_i = 1'b1; start_col_i = 10'd100; bl_code_i = 3'd1; stop_i = 1'b1;
    @(negedge clk); start_i = 1'b0; stop_i = 1'b0; #1;
    chk(int'(col_addr_o) == 100 && col_valid_o, "R11 restart addr", int'(col_addr_o), 100);
    chk(col_last_o == 1'b0, "R11 start beats stop", int'(col_last_o), 0);
    @(negedge clk); #1;
    chk(int'(col_addr_o) == 101 && col_last_o, "R11 restart second beat", int'(col_addr_o), 101);
    @(negedge clk); #1;
    chk(col_valid_o == 1'b0, "R11 restart ended", int'(col_valid_o), 0);

    // R10 stop while idle ignored
    stop_i = 1'b1;
    @(negedge clk); @(negedge clk); #1;
    chk(col_valid_o == 1'b0 && col_last_o == 1'b0, "R10 idle stop", int'(col_valid_o), 0);
    stop_i = 1'b0;
    kick(2, 0, 9);
    col_ready_i = 1'b1;
    for (int i = 0; i < 4; i++) begin
      #1;
      chk(int'(col_addr_o) == exp_addr(2, 0, 9, i), "R10 following addr", int'(col_addr_o), exp_addr(2, 0, 9, i));
      chk(col_last_o == (i == 3), "R10 R12 following last", int'(col_last_o), int'(i == 3));
      chk(col_valid_o == 1'b1, "R12 back to back", int'(col_valid_o), 1);
      @(negedge clk);
    end
    #1;
    chk(col_valid_o == 1'b0, "R10 ended", int'(col_valid_o), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule